// File: doc/BRIEF.md
# Processor Bus Address Decoder

This block turns a 24-bit processor bus address into one-hot chip selects and local offsets for the surrounding memories and I/O. Each cycle it registers the address, the write flag, the transfer size and the write data. Its outputs are then combinational from those registered values. The targets are main RAM, boot ROM, a page-map RAM, video RAM, a general status register, the generic I/O register functions, the phone relay/lead group, eight expansion card slots and four peripheral controller windows.

The decode works in levels. The top address bits pick the region. Bits 19:16 pick the function inside the lower I/O zone. A further field picks a sub-unit inside the phone group, the expansion area or the peripheral windows. The page-map RAM and the video RAM each repeat through their whole 64 KB window, and the block flags any access that lands on a repeated copy.

The only storage the block holds is the 16-bit general status register. Its value is steered onto the read data lanes according to the transfer size. A byte write changes only one lane of it. Any address that no range claims raises the undecoded flag alone.

Top module: `bus_addr_decoder`

## Requirements
- R1: An address from 0x800000 to 0xBFFFFF selects ROM (cs bit 1), with offset = address − 0x800000. ROM has priority over RAM. A write there raises tgt_wr like any decoded write, with no protection.
- R2: An address below the parameter RAM_LIMIT (default 0x200000) that is not ROM selects RAM (cs bit 0), with offset = address.
- R3: In 0x400000–0x7FFFFF, io_func = address bits 19:16, and bits 21:20 are ignored. Function 0 selects map RAM (cs bit 2), 1 the status register (cs bit 3), 2 video RAM (cs bit 4) and 9 the phone group (cs bit 6). Every other function selects the generic I/O register (cs bit 5) with offset = address bits 15:0.
- R4: For map RAM the offset is address AND 0x7FF. mirror_hit is 1 when address bits 15:11 are not all zero.
- R5: For video RAM the offset is address AND 0x7FFF. mirror_hit is 1 when address bit 15 is set.
- R6: For the phone group, sub_sel = address bits 14:12 and offset = address bits 11:0. Bit 15 has no effect on any output.
- R7: In 0xC00000–0xDFFFFF the block selects an expansion slot (cs bit 7), with sub_sel = address bits 20:18 and offset = address bits 17:0.
- R8: In 0xE00000–0xFFFFFF, address bits 18:16 with value 0–3 select a peripheral window (cs bit 8). Here sub_sel = that value and offset = address bits 15:0, and bits 20:19 are ignored. Values 4–7 raise only undecoded.
- R9: Addresses from RAM_LIMIT to 0x3FFFFF raise undecoded with all selects, offset, sub_sel, mirror_hit and tgt_wr at zero.
- R10: Exactly one of the nine selects or the undecoded flag is high in every cycle after reset.
- R11: Status reads use bus_size encoding 0 = byte, 1 = word, 2 or 3 = long. A word read returns {16'h0, reg}. A long read returns {reg, reg}. A byte read returns the high byte at an even address and the low byte at an odd address, in bits 7:0. rd_data is zero when the status register is not selected.
- R12: A synchronous reset clears the status register. A word or long write stores bus_wdata[15:0]. A byte write stores bus_wdata[7:0] into the high byte at an even address or the low byte at an odd address, and leaves the other byte unchanged.
- R13: All outputs reflect the inputs sampled at the previous rising clock edge. A status write is visible to a read sampled at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Byte address |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2/3 long |
| bus_wdata | input | 16 | Write data (low half of the bus) |
| cs | output | 9 | One-hot target select |
| cs_offset | output | 24 | Local offset inside the selected target |
| io_func | output | 4 | Function code within the lower I/O zone |
| sub_sel | output | 3 | Phone, expansion or peripheral sub-unit |
| mirror_hit | output | 1 | Access to a repeated map/video RAM copy |
| undecoded | output | 1 | No target claims the address |
| tgt_wr | output | 1 | Write strobe to the selected target |
| rd_data | output | 32 | Status register read data |

## Verification
Every decode output is due one cycle after the access is presented: inputs change on the falling edge, are sampled at the next rising edge, and are compared at the falling edge after that. A status write changes the register at the rising edge one cycle after the write itself. The reference model therefore applies its register update only after it has compared the write cycle, so a read issued back-to-back with the write is expected to show the new value. The reset check presents a status read in the first cycle after reset and expects zero.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
    localparam int ADDR_W = 24;
    localparam int NSEL   = 9;

    localparam int T_RAM  = 0;
    localparam int T_ROM  = 1;
    localparam int T_MAP  = 2;
    localparam int T_STAT = 3;
    localparam int T_VRAM = 4;
    localparam int T_IOR  = 5;
    localparam int T_PHON = 6;
    localparam int T_EXP  = 7;
    localparam int T_PERI = 8;

    localparam logic [ADDR_W-1:0] ROM_LO = 24'h800000;
    localparam logic [ADDR_W-1:0] ROM_HI = 24'hBFFFFF;

    typedef struct packed {
        logic [NSEL-1:0]   sel;
        logic [ADDR_W-1:0] off;
        logic [3:0]        fn;
        logic [2:0]        sub;
        logic              mirror;
        logic              undec;
    } dec_t;
endpackage

// File: rtl/zone_a_dec.sv
module zone_a_dec
    import bus_dec_pkg::*;
#(
    parameter int unsigned MAP_BYTES  = 2048,
    parameter int unsigned VRAM_BYTES = 32768
) (
    input  logic [19:0] addr,
    output dec_t        dec
);
    localparam logic [15:0] MAP_MASK  = 16'(MAP_BYTES - 1);
    localparam logic [15:0] VRAM_MASK = 16'(VRAM_BYTES - 1);

    logic [15:0] win;
    assign win = addr[15:0];

    always_comb begin
        dec     = '0;
        dec.fn  = addr[19:16];
        unique case (addr[19:16])
            4'h0: begin
                dec.sel[T_MAP] = 1'b1;
                dec.off        = ADDR_W'(win & MAP_MASK);
                dec.mirror     = (win & ~MAP_MASK) != 16'h0;
            end
            4'h1: begin
                dec.sel[T_STAT] = 1'b1;
                dec.off         = ADDR_W'(win);
            end
            4'h2: begin
                dec.sel[T_VRAM] = 1'b1;
                dec.off         = ADDR_W'(win & VRAM_MASK);
                dec.mirror      = (win & ~VRAM_MASK) != 16'h0;
            end
            4'h9: begin
                dec.sel[T_PHON] = 1'b1;
                dec.sub         = win[14:12];
                dec.off         = ADDR_W'(win[11:0]);
            end
            default: begin
                dec.sel[T_IOR] = 1'b1;
                dec.off        = ADDR_W'(win);
            end
        endcase
    end
endmodule

// File: rtl/zone_b_dec.sv
module zone_b_dec
    import bus_dec_pkg::*;
(
    input  logic [21:0] addr,
    output dec_t        dec
);
    always_comb begin
        dec = '0;
        if (!addr[21]) begin
            dec.sel[T_EXP] = 1'b1;
            dec.sub        = addr[20:18];
            dec.off        = ADDR_W'(addr[17:0]);
        end else if (!addr[18]) begin
            dec.sel[T_PERI] = 1'b1;
            dec.sub         = {1'b0, addr[17:16]};
            dec.off         = ADDR_W'(addr[15:0]);
        end else begin
            dec.undec = 1'b1;
        end
    end
endmodule

// File: rtl/stat_lane.sv
module stat_lane (
    input  logic [15:0] stat,
    input  logic [1:0]  size,
    input  logic        odd,
    input  logic [15:0] wdata,
    output logic [31:0] rd,
    output logic [15:0] merged
);
    always_comb begin
        unique case (size)
            2'd0: begin
                rd     = {24'h0, odd ? stat[7:0] : stat[15:8]};
                merged = odd ? {stat[15:8], wdata[7:0]} : {wdata[7:0], stat[7:0]};
            end
            2'd1: begin
                rd     = {16'h0, stat};
                merged = wdata;
            end
            default: begin
                rd     = {stat, stat};
                merged = wdata;
            end
        endcase
    end
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import bus_dec_pkg::*;
#(
    parameter int unsigned RAM_LIMIT  = 32'h200000,
    parameter int unsigned MAP_BYTES  = 2048,
    parameter int unsigned VRAM_BYTES = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [15:0]       bus_wdata,
    output logic [NSEL-1:0]   cs,
    output logic [ADDR_W-1:0] cs_offset,
    output logic [3:0]        io_func,
    output logic [2:0]        sub_sel,
    output logic              mirror_hit,
    output logic              undecoded,
    output logic              tgt_wr,
    output logic [31:0]       rd_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [1:0]        size;
        logic [15:0]       wdata;
        logic [15:0]       stat;
    } state_t;

    state_t st_d, st_q;
    dec_t   za, zb, dec;
    logic [31:0] lane_rd;
    logic [15:0] lane_wr;
    logic        ram_hit;

    zone_a_dec #(.MAP_BYTES(MAP_BYTES), .VRAM_BYTES(VRAM_BYTES)) u_za (
        .addr (st_q.addr[19:0]),
        .dec  (za)
    );

    zone_b_dec u_zb (
        .addr (st_q.addr[21:0]),
        .dec  (zb)
    );

    stat_lane u_lane (
        .stat   (st_q.stat),
        .size   (st_q.size),
        .odd    (st_q.addr[0]),
        .wdata  (st_q.wdata),
        .rd     (lane_rd),
        .merged (lane_wr)
    );

    assign ram_hit = {8'h0, st_q.addr} < RAM_LIMIT;

    // Region priority: ROM, then RAM, then the two I/O zones.
    always_comb begin
        dec = '0;
        if (st_q.addr >= ROM_LO && st_q.addr <= ROM_HI) begin
            dec.sel[T_ROM] = 1'b1;
            dec.off        = st_q.addr - ROM_LO;
        end else if (ram_hit) begin
            dec.sel[T_RAM] = 1'b1;
            dec.off        = st_q.addr;
        end else if (st_q.addr[23:22] == 2'b01) begin
            dec = za;
        end else if (st_q.addr[23:22] == 2'b11) begin
            dec = zb;
        end else begin
            dec.undec = 1'b1;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.addr  = bus_addr;
        st_d.wr    = bus_wr;
        st_d.size  = bus_size;
        st_d.wdata = bus_wdata;
        if (dec.sel[T_STAT] && st_q.wr) begin
            st_d.stat = lane_wr;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cs         = dec.sel;
    assign cs_offset  = dec.off;
    assign io_func    = dec.fn;
    assign sub_sel    = dec.sub;
    assign mirror_hit = dec.mirror;
    assign undecoded  = dec.undec;
    assign tgt_wr     = st_q.wr & ~dec.undec;
    assign rd_data    = dec.sel[T_STAT] ? lane_rd : 32'h0;
endmodule

// File: rtl/bus_addr_decoder_chk.sv
module bus_addr_decoder_chk #(
    parameter int unsigned RAM_LIMIT = 32'h200000
) (
    input logic        clk,
    input logic        rst,
    input logic [23:0] bus_addr,
    input logic        bus_wr,
    input logic [1:0]  bus_size,
    input logic [8:0]  cs,
    input logic [23:0] cs_offset,
    input logic        undecoded,
    input logic        tgt_wr,
    input logic [31:0] rd_data
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    assert_onehot_R10: assert property (@(posedge clk) disable iff (rst || !armed)
        $countones({cs, undecoded}) == 1);

    assert_rom_sel_R1: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(bus_addr) >= 24'h800000 && $past(bus_addr) <= 24'hBFFFFF) |-> cs[1]);

    assert_rom_wr_R1: assert property (@(posedge clk) disable iff (rst || !armed)
        (cs[1] && $past(bus_wr)) |-> tgt_wr);

    assert_hole_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        ({8'h0, $past(bus_addr)} >= RAM_LIMIT && $past(bus_addr) < 24'h400000) |-> (undecoded && !tgt_wr));

    assert_map_off_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        cs[2] |-> cs_offset < 24'h800);

    assert_long_dup_R11: assert property (@(posedge clk) disable iff (rst || !armed)
        (cs[3] && $past(bus_size[1])) |-> rd_data[31:16] == rd_data[15:0]);

    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (rst || !armed)
        !cs[3] |-> rd_data == 32'h0);
endmodule

bind bus_addr_decoder bus_addr_decoder_chk #(.RAM_LIMIT(RAM_LIMIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .cs        (cs),
    .cs_offset (cs_offset),
    .undecoded (undecoded),
    .tgt_wr    (tgt_wr),
    .rd_data   (rd_data)
);

// File: tb/bus_addr_decoder_bench.sv
`timescale 1ns/1ps
module bus_addr_decoder_bench;
    localparam int unsigned RAMLIM = 32'h200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [15:0] bus_wdata = '0;
    logic [8:0]  cs;
    logic [23:0] cs_offset;
    logic [3:0]  io_func;
    logic [2:0]  sub_sel;
    logic        mirror_hit, undecoded, tgt_wr;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int mstat = 0;

    always #2 clk = ~clk;

    bus_addr_decoder #(.RAM_LIMIT(RAMLIM)) u_bus_addr_decoder (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .cs(cs),
        .cs_offset(cs_offset), .io_func(io_func), .sub_sel(sub_sel),
        .mirror_hit(mirror_hit), .undecoded(undecoded), .tgt_wr(tgt_wr),
        .rd_data(rd_data)
    );

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One access: drive at a falling edge, compare one full cycle later.
    task automatic access(int a, bit w, int sz, int wd);
        int tsel, off, fn, sub, mir, und, rd, f, k;
        string tag;
        bus_addr = 24'(a); bus_wr = w; bus_size = 2'(sz); bus_wdata = 16'(wd);
        tsel = -1; off = 0; fn = 0; sub = 0; mir = 0; und = 0; rd = 0; tag = "R9";
        if (a >= 'h800000 && a <= 'hBFFFFF) begin
            tsel = 1; off = a - 'h800000; tag = "R1";
        end else if (a < int'(RAMLIM)) begin
            tsel = 0; off = a; tag = "R2";
        end else if (a >= 'h400000 && a < 'h800000) begin
            f = (a / 'h10000) % 16; fn = f; tag = "R3"; off = a % 'h10000;
            if (f == 0) begin tsel = 2; off = a % 2048; mir = (a % 'h10000) >= 2048; tag = "R4"; end
            else if (f == 1) begin tsel = 3; tag = "R11"; end
            else if (f == 2) begin tsel = 4; off = a % 32768; mir = (a % 'h10000) >= 32768; tag = "R5"; end
            else if (f == 9) begin tsel = 6; sub = (a / 4096) % 8; off = a % 4096; tag = "R6"; end
            else tsel = 5;
        end else if (a >= 'hC00000) begin
            if (a < 'hE00000) begin
                tsel = 7; sub = (a - 'hC00000) / 'h40000; off = a % 'h40000; tag = "R7";
            end else begin
                k = (a / 'h10000) % 8; tag = "R8";
                if (k < 4) begin tsel = 8; sub = k; off = a % 'h10000; end
                else und = 1;
            end
        end else und = 1;
        if (tsel == 3) begin
            if (sz == 0) rd = (a % 2 == 1) ? (mstat % 256) : (mstat / 256);
            else if (sz == 1) rd = mstat;
            else rd = mstat * 65536 + mstat;
        end
        @(negedge clk);
        check({tag, " cs"}, cs, (tsel < 0) ? 0 : (1 << tsel));
        check({tag, " offset"}, cs_offset, off);
        check({tag, " io_func"}, io_func, fn);
        check({tag, " sub_sel"}, sub_sel, sub);
        check({tag, " mirror"}, mirror_hit, mir);
        check({tag, " undecoded"}, undecoded, und);
        check({tag, " tgt_wr"}, tgt_wr, (w && !und) ? 1 : 0);
        check({tag, " rd_data"}, {32'h0, rd_data}, {32'h0, 32'(rd)});
        check("R10 one-hot", $countones({cs, undecoded}), 1);
        // R12: the register takes the write only after this cycle is compared
        if (tsel == 3 && w) begin
            if (sz == 0) begin
                if (a % 2 == 1) mstat = (mstat / 256) * 256 + (wd % 256);
                else mstat = (wd % 256) * 256 + (mstat % 256);
            end else mstat = wd % 65536;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset value, read right after reset (word, then long)
        access('h410000, 0, 1, 0);
        access('h410002, 0, 2, 0);
        // R2 RAM / R1 ROM incl. write pass-through and boundaries
        access('h000000, 0, 2, 0);
        access('h1FFFFF, 1, 0, 'h12);
        access('h800000, 1, 1, 'hBEEF);
        access('hBFFFFF, 0, 0, 0);
        // R9 holes
        access('h200000, 1, 1, 'h1111);
        access('h3FFFFF, 0, 2, 0);
        // R4 map RAM image and mirrors
        access('h400000, 0, 1, 0);
        access('h4007FF, 0, 1, 0);
        access('h400800, 1, 1, 'h55);
        access('h70FFFF, 0, 0, 0);
        // R5 video RAM
        access('h420000, 0, 1, 0);
        access('h427FFF, 0, 1, 0);
        access('h428000, 0, 1, 0);
        // R3 generic functions
        access('h4A0000, 1, 1, 'h0F00);
        access('h7F5123, 0, 1, 0);
        access('h5C0000, 0, 0, 0);
        // R6 phone group, bit 15 alias
        access('h490000, 0, 1, 0);
        access('h498000, 0, 1, 0);
        access('h49F123, 0, 1, 0);
        access('h497ABC, 0, 1, 0);
        // R7 expansion slots
        access('hC00000, 0, 2, 0);
        access('hDC1234, 1, 1, 'h7);
        access('hD7FFFF, 0, 0, 0);
        // R8 peripheral windows and undecoded codes
        access('hE00000, 0, 1, 0);
        access('hF9ABCD, 0, 1, 0);
        access('hEB0000, 0, 1, 0);
        access('hE40000, 1, 1, 'h99);
        access('hFF0000, 0, 1, 0);
        // R11/R12/R13 status register: write then back-to-back reads
        access('h410000, 1, 1, 'hA55A);
        access('h410000, 0, 2, 0);
        access('h410000, 0, 0, 0);
        access('h410001, 0, 0, 0);
        access('h410001, 1, 0, 'h3C);
        access('h410000, 0, 1, 0);
        access('h71FFFE, 1, 0, 'hC7);
        access('h410000, 0, 1, 0);
        access('h410000, 1, 2, 'h1234);
        access('h510000, 0, 3, 0);
        // Pseudo-random sweep
        lf = 'h5A3C1;
        for (int i = 0; i < 400; i++) begin
            lf = (lf * 1103515245 + 12345) & 'h7FFFFFFF;
            access((lf / 64) % 'h1000000, (lf / 8) % 2, (lf / 2) % 4, lf % 65536);
            if (i % 7 == 0) access('h410000 + (lf % 2), 0, (lf / 4) % 4, 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule